// File: doc/BRIEF.md
# Dwell-Time Idle Transition Checker

This block is a synthesizable hardware monitor for a controller whose state appears on a 3-bit bus and whose number of pending requests appears on a 6-bit bus. When the state is ACTIVE and exactly one request is pending, the monitor starts tracking. It then requires two things from that cycle on. The state must hold ACTIVE for a first, shorter stretch. The request count must hold at one for a second, longer stretch. If either condition breaks early, the attempt is dropped without any report, and the monitor waits for the next qualifying cycle.

Once the longer stretch completes, a short response window opens. In that window the controller must show IDLE within one to five cycles. Seeing IDLE gives a one-cycle pass pulse. Running out of the window gives a one-cycle error pulse. A busy flag shows that an attempt or its window is in progress. Attempts never overlap. The monitor sits beside the controller on silicon and turns a timing rule into pulses that can be counted or used to raise an interrupt.

Top module: `idle_dwell_monitor`

## Requirements
- R1: While not busy, a sampled cycle with state code 1 (ACTIVE) and request count exactly 1 arms the monitor. `busy` is high from the next cycle onward. Any other combination leaves `busy` low.
- R2: The arming cycle and the next 20 sampled cycles (21 in all) must show state code 1. Otherwise the attempt ends: `busy` falls with no pass and no error pulse.
- R3: The arming cycle and the next 47 sampled cycles (48 in all) must show a request count of exactly 1. Otherwise the attempt ends silently, in the same way as in R2.
- R4: From the 22nd tracked cycle up to the 48th, the state code may take any value without ending the attempt.
- R5: On the 1st to 5th sampled cycles after the 48th, the first one showing state code 0 (IDLE) produces a one-cycle `pass_pulse` on the following cycle. `busy` drops on that same cycle.
- R6: If none of those five cycles shows state code 0, `err_pulse` is high for one cycle, on the cycle after the fifth, and `busy` drops with it.
- R7: While busy, qualifying cycles are ignored. Tracking does not restart, and the window closes at its fixed position.
- R8: The active-low reset clears `busy`, `pass_pulse` and `err_pulse` at once, and it drops any attempt in progress.
- R9: State code 2 (LOW_POWER) and unused codes count as neither ACTIVE nor IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_state | input | 3 | Observed controller state: 0 idle, 1 active, 2 low power |
| req_count | input | 6 | Observed number of outstanding requests |
| pass_pulse | output | 1 | One-cycle pulse: IDLE reached inside the window |
| err_pulse | output | 1 | One-cycle pulse: window expired without IDLE |
| busy | output | 1 | Attempt or response window in progress |

## Verification
The bench targets the edges of each dwell stretch. A state drop on the 21st tracked cycle must abandon the attempt, while a low-power state on the 22nd must not. A design off by one on either count would report a pass where none is due, or lose a valid attempt. The bench puts IDLE on the first and on the fifth window cycle, and also keeps it away for all five. A window that is too short or too long would turn passes into errors, or the other way round. It also keeps the inputs qualifying through the whole window and resets in the middle of an attempt. A monitor that re-armed while busy, or that kept stale tracking across reset, would then show `busy` and the pulses at the wrong cycles against the bench's reference model.

// File: rtl/idle_dwell_pkg.sv
`timescale 1ns/1ps
package idle_dwell_pkg;
  typedef enum logic [2:0] {
    CS_IDLE   = 3'd0,
    CS_ACTIVE = 3'd1,
    CS_LOWPWR = 3'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_DWELL = 2'd1,
    PH_RESP  = 2'd2
  } phase_e;
endpackage

// File: rtl/idle_dwell_decode.sv
`timescale 1ns/1ps
module idle_dwell_decode
  import idle_dwell_pkg::*;
#(
  parameter int STATE_W = 3,
  parameter int REQ_W   = 6
) (
  input  logic [STATE_W-1:0] ctl_state,
  input  logic [REQ_W-1:0]   req_count,
  output logic               is_active,
  output logic               is_idle,
  output logic               req_one
);
  // Only exact codes qualify; low power and unused codes match neither (R9)
  always_comb begin
    is_active = (ctl_state == STATE_W'(CS_ACTIVE));
    is_idle   = (ctl_state == STATE_W'(CS_IDLE));
    req_one   = (req_count == REQ_W'(1));
  end
endmodule

// File: rtl/idle_dwell_span.sv
`timescale 1ns/1ps
module idle_dwell_span #(
  parameter int STATE_DWELL = 21,
  parameter int REQ_DWELL   = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  input  logic state_ok,
  input  logic req_ok,
  output logic fail,
  output logic done
);
  localparam int CW = $clog2(REQ_DWELL + 1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_nxt;
  logic          cnt_en, state_need;

  // cnt_q = tracked cycles already accepted; the arming cycle counts as one
  always_comb begin
    cnt_nxt    = cnt_q + CW'(1);
    state_need = (cnt_nxt <= CW'(STATE_DWELL));
    fail       = run && (!req_ok || (state_need && !state_ok));
    done       = run && !fail && (cnt_nxt == CW'(REQ_DWELL));
    cnt_en     = arm || run;
    cnt_d      = arm ? CW'(1) : cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the request stretch never runs past its length
  a_r3_span_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(REQ_DWELL)));

  // R3: a request count other than one ends tracking in that cycle
  a_r3_req_break: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !req_ok) |-> !done);
endmodule

// File: rtl/idle_dwell_window.sv
`timescale 1ns/1ps
module idle_dwell_window #(
  parameter int WIN_MIN = 1,
  parameter int WIN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic is_idle,
  output logic hit,
  output logic expire
);
  localparam int KW = $clog2(WIN_MAX + 1);

  logic [KW-1:0] k_q, k_d, k_nxt;
  logic          k_en;

  always_comb begin
    k_nxt  = k_q + KW'(1);
    hit    = run && is_idle && (k_nxt >= KW'(WIN_MIN));
    expire = run && !hit && (k_nxt == KW'(WIN_MAX));
    k_en   = start || run;
    k_d    = start ? '0 : k_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    k_q <= '0;
    else if (k_en) k_q <= k_d;
  end

  // R6: the window never outlives its last cycle
  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (k_q < KW'(WIN_MAX)));
endmodule

// File: rtl/idle_dwell_monitor.sv
`timescale 1ns/1ps
module idle_dwell_monitor
  import idle_dwell_pkg::*;
#(
  parameter int STATE_W     = 3,
  parameter int REQ_W       = 6,
  parameter int STATE_DWELL = 21,
  parameter int REQ_DWELL   = 48,
  parameter int WIN_MIN     = 1,
  parameter int WIN_MAX     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ctl_state,
  input  logic [REQ_W-1:0]   req_count,
  output logic               pass_pulse,
  output logic               err_pulse,
  output logic               busy
);
  phase_e phase_q, phase_d;
  logic   is_active, is_idle, req_one;
  logic   arm, run_dwell, run_win;
  logic   span_fail, span_done, win_hit, win_expire;
  logic   pass_d, err_d, busy_d;
  logic   pass_q, err_q, busy_q;

  idle_dwell_decode #(.STATE_W(STATE_W), .REQ_W(REQ_W)) u_dec (
    .ctl_state (ctl_state),
    .req_count (req_count),
    .is_active (is_active),
    .is_idle   (is_idle),
    .req_one   (req_one)
  );

  idle_dwell_span #(.STATE_DWELL(STATE_DWELL), .REQ_DWELL(REQ_DWELL)) u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .run      (run_dwell),
    .state_ok (is_active),
    .req_ok   (req_one),
    .fail     (span_fail),
    .done     (span_done)
  );

  idle_dwell_window #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (span_done),
    .run     (run_win),
    .is_idle (is_idle),
    .hit     (win_hit),
    .expire  (win_expire)
  );

  // Next-state logic
  always_comb begin
    phase_d   = phase_q;
    arm       = 1'b0;
    pass_d    = 1'b0;
    err_d     = 1'b0;
    run_dwell = (phase_q == PH_DWELL);
    run_win   = (phase_q == PH_RESP);
    unique case (phase_q)
      PH_WAIT: begin
        if (is_active && req_one) begin
          arm     = 1'b1;
          phase_d = PH_DWELL;
        end
      end
      PH_DWELL: begin
        if (span_fail)      phase_d = PH_WAIT;
        else if (span_done) phase_d = PH_RESP;
      end
      PH_RESP: begin
        if (win_hit) begin
          pass_d  = 1'b1;
          phase_d = PH_WAIT;
        end else if (win_expire) begin
          err_d   = 1'b1;
          phase_d = PH_WAIT;
        end
      end
      default: phase_d = PH_WAIT;
    endcase
    busy_d = (phase_d != PH_WAIT);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
      busy_q  <= busy_d;
    end
  end

  assign pass_pulse = pass_q;
  assign err_pulse  = err_q;
  assign busy       = busy_q;

  // R1: a qualifying cycle while not busy makes busy high next cycle
  a_r1_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && is_active && req_one) |=> busy);

  // R5: pass only follows an IDLE sample and lasts one cycle
  a_r5_pass_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> ($past(ctl_state) == STATE_W'(CS_IDLE)));
  a_r5_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse);

  // R6: error never follows an IDLE sample and never coincides with pass
  a_r6_err_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(ctl_state) != STATE_W'(CS_IDLE)));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse && err_pulse));

  // R7: a pulse always closes an attempt that was in progress
  a_r7_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_pulse || err_pulse) |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_idle_dwell_monitor.sv
`timescale 1ns/1ps
module sim_idle_dwell_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] st = 3'd0;
  logic [5:0] rq = 6'd0;
  logic       pass_pulse, err_pulse, busy;

  int total = 0, bad = 0, ncyc = 0;
  int np = 0, ne = 0, na = 0;
  bit pb = 1'b0;

  // reference model state
  bit m_trk = 1'b0, m_pass = 1'b0, m_err = 1'b0, m_busy = 1'b0;
  int m_age = 0;

  localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_LP = 3'd2;

  idle_dwell_monitor u0 (
    .clk(clk), .rst_n(rst_n), .ctl_state(st), .req_count(rq),
    .pass_pulse(pass_pulse), .err_pulse(err_pulse), .busy(busy)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: one age counter from the arming cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trk = 0; m_age = 0; m_pass = 0; m_err = 0; m_busy = 0;
    end else begin
      m_pass = 0; m_err = 0;
      if (!m_trk) begin
        if (st == S_ACT && rq == 6'd1) begin m_trk = 1; m_age = 1; end
      end else begin
        m_age++;
        if (m_age <= 48) begin
          if ((m_age <= 21 && st != S_ACT) || rq != 6'd1) m_trk = 0;
        end else if (st == S_IDLE) begin
          m_pass = 1; m_trk = 0;
        end else if (m_age == 53) begin
          m_err = 1; m_trk = 0;
        end
      end
      m_busy = m_trk;
    end
  end

  // Per-cycle comparison and pulse tallies
  always @(negedge clk) begin
    chk("R1/R7 busy", busy, m_busy);
    chk("R5 pass_pulse", pass_pulse, m_pass);
    chk("R6 err_pulse", err_pulse, m_err);
    if (rst_n) begin
      if (pass_pulse) np++;
      if (err_pulse) ne++;
      if (pb && !busy && !pass_pulse && !err_pulse) na++;
    end
    pb = busy;
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input logic [2:0] s, input logic [5:0] r);
    st = s; rq = r;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic hold(input logic [2:0] s, input logic [5:0] r, input int n);
    for (int i = 0; i < n; i++) cyc(s, r);
  endtask

  task automatic tally(input string tag, input int p0, input int e0, input int a0,
                       input int dp, input int de, input int da);
    chk({tag, " pass count"}, np - p0, dp);
    chk({tag, " err count"}, ne - e0, de);
    chk({tag, " abandon count"}, na - a0, da);
  endtask

  initial begin
    int p0, e0, a0;
    @(negedge clk); @(negedge clk);
    chk("R8 busy in reset", busy, 0);
    chk("R8 pass in reset", pass_pulse, 0);
    rst_n = 1'b1;
    hold(S_IDLE, 0, 2);

    // R1: non-qualifying combinations never arm
    cyc(S_LP, 1); cyc(S_ACT, 0); cyc(S_ACT, 2); cyc(3'd3, 1);
    chk("R1 no arm", busy, 0);

    // R5: IDLE on first window cycle
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 48); cyc(S_IDLE, 0); hold(S_IDLE, 0, 3);
    tally("R5 first", p0, e0, a0, 1, 0, 0);

    // R5: IDLE on fifth window cycle
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 48); hold(S_ACT, 0, 4); cyc(S_IDLE, 0); hold(S_IDLE, 0, 3);
    tally("R5 last", p0, e0, a0, 1, 0, 0);

    // R6: IDLE never seen
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 48); hold(S_ACT, 0, 5); hold(S_IDLE, 0, 3);
    tally("R6 expire", p0, e0, a0, 0, 1, 0);

    // R2: state drops early
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 10); cyc(S_IDLE, 1); hold(S_IDLE, 0, 3);
    tally("R2 early drop", p0, e0, a0, 0, 0, 1);

    // R2: state leaves on the 21st tracked cycle
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 20); cyc(S_LP, 1); hold(S_IDLE, 0, 3);
    tally("R2 edge", p0, e0, a0, 0, 0, 1);

    // R4 and R9: low power from cycle 22 is allowed, IDLE on window cycle 3
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 21); hold(S_LP, 1, 27); hold(S_LP, 0, 2); cyc(S_IDLE, 0);
    hold(S_IDLE, 0, 3);
    tally("R4 free state", p0, e0, a0, 1, 0, 0);

    // R3: request count breaks on cycle 40
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 39); cyc(S_ACT, 2); hold(S_IDLE, 0, 3);
    tally("R3 req break", p0, e0, a0, 0, 0, 1);

    // R7: qualifying inputs through the window do not restart it
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 48); hold(S_ACT, 1, 5);
    chk("R7 busy after err", busy, 0);
    hold(S_IDLE, 0, 3);
    tally("R7 no restart", p0, e0, a0, 0, 1, 0);

    // R9: low power in the window is not IDLE
    p0 = np; e0 = ne; a0 = na;
    hold(S_ACT, 1, 48); hold(S_LP, 1, 5); hold(S_IDLE, 0, 3);
    tally("R9 low power", p0, e0, a0, 0, 1, 0);

    // R8: reset mid-attempt
    hold(S_ACT, 1, 30);
    rst_n = 1'b0;
    hold(S_ACT, 1, 2);
    chk("R8 busy cleared", busy, 0);
    rst_n = 1'b1;
    hold(S_IDLE, 0, 2);
    chk("R8 idle after reset", busy, 0);

    // Mixed stimulus compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r, q;
      logic [2:0] s;
      r = $urandom_range(0, 99);
      q = $urandom_range(0, 99);
      s = (r < 4) ? S_IDLE : (r < 6) ? S_LP : (r < 7) ? 3'd5 : S_ACT;
      cyc(s, (q < 2) ? 6'd0 : (q < 3) ? 6'd2 : 6'd1);
    end
    hold(S_IDLE, 0, 60);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule